// File: doc/BRIEF.md
# Flash Embedded Program Engine

This block models the program step of a NOR flash array held in a small internal memory. A command sequencer hands it one request at a time: a byte address, a data value, and a width select for byte or word. Once a request is taken, the engine holds a busy period whose length is a parameter, with a shorter count for accelerated requests. At the end of that period it commits the write to the array and returns to read mode.

Flash cells can only move from 1 to 0. The committed value is therefore the old contents ANDed with the new data. An attempt to raise a bit completes with the usual status but leaves the bit at 0. While the engine is busy, reads do not return array data. They return a polling word: an inverted copy of data bit 7 and a bit that flips on every read. New requests that arrive while busy are dropped. A synchronous reset cancels an operation in progress and writes nothing.

Top module: `flash_prog_engine`

## Requirements
- R1: During reset and on the first cycle after it, `ready` is 1 and `rd_data` is 0.
- R2: A request taken with `accel` at 0 drives `ready` to 0 from the next cycle. `ready` stays 0 for exactly PROG_CYCLES cycles and then returns to 1.
- R3: A request taken with `accel` at 1 keeps `ready` at 0 for exactly ACCEL_CYCLES cycles.
- R4: A program stores the old word ANDed with the new data. A bit that is 0 stays 0 even when the new data has a 1 there, and the operation still finishes normally.
- R5: With `req_byte` at 1, `req_addr[0]` picks the lane: 0 is bits 7:0 and 1 is bits 15:8. Only `req_data[7:0]` is applied, and the other lane is unchanged. An idle read with `rd_byte` at 1 returns the selected lane zero-extended. With `rd_byte` at 0, an idle read returns the whole word and the low address bit is not used.
- R6: A request presented while `ready` is 0 is ignored. It neither starts an operation nor changes any array location.
- R7: A read issued while busy returns a polling word. Bit 7 is the inverse of bit 7 of the data being programmed. Bit 6 takes the opposite value on each successive polling read. All other bits are 0.
- R8: Reset during a busy period returns `ready` to 1 on the next cycle, and the targeted location keeps its previous contents.
- R9: Any address may be programmed in any order, including the lowest and highest locations.
- R10: A read issued when idle shows the array contents on `rd_data` one cycle later. Before any program, every location reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Program request strobe |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | 16 | Program data (low byte used in byte mode) |
| req_byte | input | 1 | 1 selects byte width, 0 selects word width |
| accel | input | 1 | Use the shorter accelerated busy count |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_byte | input | 1 | 1 returns one byte lane, 0 the whole word |
| rd_data | output | 16 | Registered read result or polling word |
| ready | output | 1 | 1 when idle, 0 while programming |

## Verification
A bad busy counter or state register shows on `ready` within one cycle of the expected edge. A count that is off by one moves the rising edge of `ready` by exactly that cycle. A broken merge, lane select or abort path shows on the first read of the affected word. That read appears on `rd_data` one cycle after it is issued. A stuck or wrongly latched polling bit shows on the first or second read of a busy period. Because the reference model is compared with `ready` and `rd_data` on every clock, each of these faults is reported in the cycle it first reaches the ports.

// File: rtl/flash_prog_pkg.sv
// Shared types and helpers for the flash program engine.
// Assumes a 16-bit word array addressed in bytes; lane 1 is the high byte.
package flash_prog_pkg;

    typedef logic [15:0] word_t;
    typedef logic [7:0]  byte_t;

    typedef enum logic {
        ST_READ = 1'b0,
        ST_BUSY = 1'b1
    } eng_state_e;

    // Build the AND pattern for a program: ones where nothing is to change.
    function automatic word_t prog_pattern(input word_t data, input logic byte_mode, input logic hi_lane);
        word_t pat;
        if (!byte_mode)
            pat = data;
        else if (hi_lane)
            pat = {data[7:0], 8'hFF};
        else
            pat = {8'hFF, data[7:0]};
        return pat;
    endfunction

endpackage

// File: rtl/fpe_timer.sv
// Busy-period timer for the program engine.
// Loads one of two counts on start and flags the final busy cycle as done.
// Assumes PROG_CYCLES and ACCEL_CYCLES are both at least 1.
module fpe_timer
    import flash_prog_pkg::*;
#(
    parameter int PROG_CYCLES  = 20,
    parameter int ACCEL_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic accel,
    output logic busy,
    output logic done
);
    localparam int MAX_CYC = (PROG_CYCLES > ACCEL_CYCLES) ? PROG_CYCLES : ACCEL_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ACCEL_LOAD = CNT_W'(ACCEL_CYCLES - 1);

    eng_state_e       state;
    logic [CNT_W-1:0] cnt;

    // Step the busy state and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READ;
            cnt   <= '0;
        end else begin
            case (state)
                ST_READ: begin
                    if (start) begin
                        state <= ST_BUSY;
                        cnt   <= accel ? ACCEL_LOAD : PROG_LOAD;
                    end
                end
                ST_BUSY: begin
                    if (cnt == '0)
                        state <= ST_READ;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= ST_READ;
            endcase
        end
    end

    // Decode busy and the commit cycle.
    always_comb begin
        busy = (state == ST_BUSY);
        done = busy && (cnt == '0);
    end

endmodule

// File: rtl/fpe_array.sv
// Word array with a flash-style write: the stored word can only lose ones.
// Every location starts erased (all ones). One write port, one combinational read port.
module fpe_array
    import flash_prog_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_pattern,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word
);
    localparam int DEPTH = 2 ** IDX_W;

    word_t mem [DEPTH];

    // Start from the erased state.
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
    end

    // Commit a program by clearing bits only.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= mem[wr_idx] & wr_pattern;
    end

    // Present the addressed word.
    always_comb rd_word = mem[rd_idx];

endmodule

// File: rtl/fpe_status.sv
// Registered read path: array data when idle, polling word when busy.
// The polling toggle bit flips on every read taken while busy.
module fpe_status
    import flash_prog_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_en,
    input  logic  busy,
    input  logic  rd_byte,
    input  logic  rd_lane,
    input  logic  pgm_bit7,
    input  word_t arr_word,
    output word_t rd_data
);
    logic  toggle;
    word_t idle_word;

    // Select the idle read value by width and lane.
    always_comb begin
        if (!rd_byte)
            idle_word = arr_word;
        else if (rd_lane)
            idle_word = {8'h00, arr_word[15:8]};
        else
            idle_word = {8'h00, arr_word[7:0]};
    end

    // Register the read result and advance the toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            toggle  <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rd_data <= {8'h00, ~pgm_bit7, toggle, 6'b000000};
                toggle  <= ~toggle;
            end else begin
                rd_data <= idle_word;
            end
        end
    end

endmodule

// File: rtl/flash_prog_engine.sv
// Embedded program engine top: takes one request, holds busy for a
// parameterised count, commits an AND-merge into the array, then returns to read mode.
// Assumes the command sequencer presents already-decoded program requests.
module flash_prog_engine
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int PROG_CYCLES  = 20,
    parameter int ACCEL_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_data,
    input  logic              req_byte,
    input  logic              accel,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_byte,
    output logic [15:0]       rd_data,
    output logic              ready
);
    localparam int IDX_W = ADDR_W - 1;

    logic              busy;
    logic              done;
    logic              start;
    logic [ADDR_W-1:0] lat_addr;
    word_t             lat_data;
    logic              lat_byte;
    word_t             arr_word;
    word_t             pattern;

    // Accept a request only while in read mode.
    always_comb start = req_valid && !busy;

    // Hold the request during the busy period; release it once committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
            lat_byte <= 1'b0;
        end else if (start) begin
            lat_addr <= req_addr;
            lat_data <= req_data;
            lat_byte <= req_byte;
        end else if (done) begin
            lat_addr <= '0;
            lat_data <= '0;
            lat_byte <= 1'b0;
        end
    end

    // Form the write pattern for the selected width and lane.
    always_comb pattern = prog_pattern(lat_data, lat_byte, lat_addr[0]);

    fpe_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ACCEL_CYCLES(ACCEL_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .accel(accel),
        .busy (busy),
        .done (done)
    );

    fpe_array #(
        .IDX_W(IDX_W)
    ) u_array (
        .clk       (clk),
        .wr_en     (done && rst_n),
        .wr_idx    (lat_addr[ADDR_W-1:1]),
        .wr_pattern(pattern),
        .rd_idx    (rd_addr[ADDR_W-1:1]),
        .rd_word   (arr_word)
    );

    fpe_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .busy    (busy),
        .rd_byte (rd_byte),
        .rd_lane (rd_addr[0]),
        .pgm_bit7(lat_data[7]),
        .arr_word(arr_word),
        .rd_data (rd_data)
    );

    // Ready/busy pin.
    always_comb ready = !busy;

endmodule

// File: rtl/flash_prog_engine_chk.sv
// Port-level checker for the program engine, bound to every instance of the top.
// Tracks the length of each busy run and the data bit 7 of the accepted request.
module flash_prog_engine_chk #(
    parameter int PROG_CYCLES  = 20,
    parameter int ACCEL_CYCLES = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_d7,
    input logic        ready,
    input logic        rd_en,
    input logic [15:0] rd_data
);
    localparam int MAX_CYC = (PROG_CYCLES > ACCEL_CYCLES) ? PROG_CYCLES : ACCEL_CYCLES;

    logic        cap7;
    logic [31:0] low_run;

    // Capture bit 7 of each accepted request and count cycles with ready low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap7    <= 1'b0;
            low_run <= '0;
        end else begin
            if (req_valid && ready) cap7 <= req_d7;
            low_run <= ready ? 32'd0 : low_run + 32'd1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (ready && rd_data == 16'h0000));

    assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (low_run < MAX_CYC));

    assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && $past(rst_n)) |-> (low_run == PROG_CYCLES || low_run == ACCEL_CYCLES));

    assert_start_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(req_valid));

    assert_poll_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && rd_en) |=> (rd_data[15:8] == 8'h00 && rd_data[5:0] == 6'h00 && rd_data[7] == !cap7));

endmodule

bind flash_prog_engine flash_prog_engine_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .ACCEL_CYCLES(ACCEL_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_d7   (req_data[7]),
    .ready    (ready),
    .rd_en    (rd_en),
    .rd_data  (rd_data)
);

// File: tb/sim_flash_prog_engine.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the outputs on every clock,
// plus directed checks per requirement.
module sim_flash_prog_engine;
    localparam int AW    = 7;
    localparam int PC    = 20;
    localparam int AC    = 6;
    localparam int DEPTH = 2 ** (AW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          req_byte = 1'b0;
    logic          accel = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_byte = 1'b0;
    logic [15:0]   rd_data;
    logic          ready;

    always #10 clk = ~clk;

    flash_prog_engine #(.ADDR_W(AW), .PROG_CYCLES(PC), .ACCEL_CYCLES(AC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_byte(req_byte), .accel(accel), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_byte(rd_byte), .rd_data(rd_data), .ready(ready)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    string cur_req = "R1";
    bit    started = 0;

    // Reference model state
    logic [15:0] m_mem [DEPTH];
    bit          m_busy = 0;
    int          m_cnt = 0;
    int          m_addr = 0;
    logic [15:0] m_data = '0;
    bit          m_byte = 0;
    bit          m_tog = 0;
    logic [15:0] m_rd = '0;

    initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'hFFFF;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Model update at each rising edge from the inputs seen there.
    always @(posedge clk) begin
        started = 1;
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_rd = '0; m_tog = 0;
        end else begin
            if (rd_en) begin
                if (m_busy) begin
                    m_rd  = {8'h00, ~m_data[7], m_tog, 6'b0};
                    m_tog = ~m_tog;
                end else if (!rd_byte) begin
                    m_rd = m_mem[rd_addr / 2];
                end else begin
                    m_rd = rd_addr[0] ? {8'h00, m_mem[rd_addr / 2][15:8]} : {8'h00, m_mem[rd_addr / 2][7:0]};
                end
            end
            if (m_busy) begin
                if (m_cnt == 0) begin
                    if (!m_byte) m_mem[m_addr / 2] = m_mem[m_addr / 2] & m_data;
                    else if (m_addr % 2 == 1) m_mem[m_addr / 2][15:8] = m_mem[m_addr / 2][15:8] & m_data[7:0];
                    else m_mem[m_addr / 2][7:0] = m_mem[m_addr / 2][7:0] & m_data[7:0];
                    m_busy = 0;
                end else begin
                    m_cnt--;
                end
            end else if (req_valid) begin
                m_busy = 1; m_addr = req_addr; m_data = req_data; m_byte = req_byte;
                m_cnt  = (accel ? AC : PC) - 1;
            end
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            check(cur_req, {15'd0, ready}, {15'd0, ~m_busy}, "ready vs model");
            check(cur_req, rd_data, m_rd, "rd_data vs model");
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 60000) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic do_prog(input logic [AW-1:0] a, input logic [15:0] d, input logic b, input logic acc, output int lowc);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_data = d; req_byte = b; accel = acc;
        @(negedge clk);
        req_valid = 0; accel = 0;
        lowc = 0;
        while (!ready) begin lowc++; @(negedge clk); end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic b, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1; rd_addr = a; rd_byte = b;
        @(negedge clk);
        rd_en = 0;
        v = rd_data;
    endtask

    initial begin
        int          n;
        logic [15:0] v;
        logic [15:0] p0;
        logic [15:0] p1;

        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check("R1", {15'd0, ready}, 16'd1, "ready in reset");
        check("R1", rd_data, 16'h0000, "rd_data in reset");
        rst_n = 1;
        @(negedge clk);
        check("R1", {15'd0, ready}, 16'd1, "ready after reset");

        // R10: erased read with one-cycle latency
        cur_req = "R10";
        do_read(7'd20, 1'b0, v);
        check("R10", v, 16'hFFFF, "erased word read");

        // R2: normal busy length
        cur_req = "R2";
        do_prog(7'd20, 16'h12F0, 1'b0, 1'b0, n);
        check("R2", 16'(n), 16'(PC), "normal busy cycles");

        // R4: AND merge, ones cannot be restored
        cur_req = "R4";
        do_read(7'd20, 1'b0, v);
        check("R4", v, 16'h12F0, "first program");
        do_prog(7'd20, 16'hFF0F, 1'b0, 1'b0, n);
        check("R4", 16'(n), 16'(PC), "set attempt still completes");
        do_read(7'd20, 1'b0, v);
        check("R4", v, 16'h1200, "zeros kept after set attempt");

        // R5: byte lanes
        cur_req = "R5";
        do_prog(7'd31, 16'hAA3C, 1'b1, 1'b0, n);
        do_read(7'd30, 1'b0, v);
        check("R5", v, 16'h3CFF, "high lane written, low lane kept");
        do_read(7'd31, 1'b1, v);
        check("R5", v, 16'h003C, "byte read high lane");
        do_read(7'd30, 1'b1, v);
        check("R5", v, 16'h00FF, "byte read low lane");
        do_prog(7'd30, 16'h0081, 1'b1, 1'b0, n);
        do_read(7'd31, 1'b0, v);
        check("R5", v, 16'h3C81, "low lane write, word read ignores addr bit 0");

        // R3: accelerated busy length
        cur_req = "R3";
        do_prog(7'd4, 16'hA5A5, 1'b0, 1'b1, n);
        check("R3", 16'(n), 16'(AC), "accelerated busy cycles");

        // R6 and R7: ignored request and polling reads while busy
        cur_req = "R7";
        @(negedge clk);
        req_valid = 1; req_addr = 7'd50; req_data = 16'h0080; req_byte = 0;
        @(negedge clk);
        req_addr = 7'd52; req_data = 16'h0000;
        rd_en = 1; rd_addr = 7'd50; rd_byte = 0;
        @(negedge clk);
        req_valid = 0;
        p0 = rd_data;
        check("R7", {8'h00, p0[7], 7'd0}, 16'h0000, "poll bit 7 inverse of data bit 7");
        check("R7", {p0[15:8], 2'b00, p0[5:0]}, 16'h0000, "poll other bits zero");
        @(negedge clk);
        p1 = rd_data;
        check("R7", {15'd0, p1[6]}, {15'd0, ~p0[6]}, "poll bit 6 toggles");
        rd_en = 0;
        cur_req = "R6";
        while (!ready) @(negedge clk);
        do_read(7'd52, 1'b0, v);
        check("R6", v, 16'hFFFF, "request while busy ignored");
        do_read(7'd50, 1'b0, v);
        check("R6", v, 16'h0080, "first request committed");

        // R9: extreme addresses, descending order
        cur_req = "R9";
        do_prog(7'd127, 16'h0F0F, 1'b0, 1'b0, n);
        do_prog(7'd0, 16'hF00F, 1'b0, 1'b0, n);
        do_read(7'd126, 1'b0, v);
        check("R9", v, 16'h0F0F, "top word");
        do_read(7'd1, 1'b0, v);
        check("R9", v, 16'hF00F, "bottom word");

        // R8: reset aborts a program
        cur_req = "R8";
        @(negedge clk);
        req_valid = 1; req_addr = 7'd40; req_data = 16'h0000; req_byte = 0;
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R8", {15'd0, ready}, 16'd1, "ready after abort");
        repeat (PC + 2) @(negedge clk);
        do_read(7'd40, 1'b0, v);
        check("R8", v, 16'hFFFF, "aborted location unchanged");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule